// File: doc/BRIEF.md
# JEDEC Flash Command Sequencer

This block sits between a byte-wide bus front end and the array port of a flash memory. It watches the stream of byte writes for the standard unlock-and-command sequences. When a sequence is complete, it issues one operation request (kind, address and data) to the array: byte program, 4 KB sector erase, 64 KB block erase or whole-chip erase. It then models the internal write time with a busy counter. Program and erase each have their own duration parameter.

While the internal operation runs, a read does not return array contents. It returns a status byte for end-of-write polling. Bit 7 carries the inverse of the expected final bit 7. Bit 6 flips on every read. Once the counter expires, reads pass the array data through again.

The sequencer also has an identification mode, in which two fixed addresses return the maker code and the device code. Two lock inputs block program and erase. One guards the top 64 KB block and the other guards everything below it.

Top module: `jedec_cmd_seq`

## Requirements
- R1: After reset, busy and opValid are low, rdData is 00h and the block is not in identification mode.
- R2: A program sequence is four writes: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then any write. In the next cycle opValid is high for exactly one cycle with opKind=0 and the address and data of the fourth write.
- R3: An erase sequence is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then a sixth write. If that write is 30h at any address, the block issues opKind=1 with address bits [11:0] cleared and opData=FFh.
- R4: A sixth erase write of 50h at any address issues opKind=2 with address bits [15:0] cleared and opData=FFh.
- R5: A sixth erase write of 10h at 5555h issues opKind=3 with address 0 and opData=FFh. This happens only while ppMode is high; otherwise no request is made and busy stays low.
- R6: Command addresses are matched on address bits [14:0] only. Higher bits are don't-care, and a mismatch in bits [14:0] breaks the sequence.
- R7: A write that does not fit the current step returns the sequencer to idle. If that write is itself AAh@5555h, it counts as a fresh first step.
- R8: After a launch, busy stays high for exactly PROG_CYCLES cycles (program) or ERASE_CYCLES cycles (erase). Writes made while busy start nothing.
- R9: A read while busy returns bit7 = inverse of the target bit 7 (the programmed data bit 7, or 1 for erase), bit6 = a toggle that is 0 on the first read and flips on each later read, and bits [5:0] = 0. Once busy is low, reads return arrRdData.
- R10: AAh@5555h, 55h@2AAAh, 90h@5555h enters identification mode. There, address 0 reads MFR_ID (BFh), address 1 reads DEV_ID (5Bh) and any other address reads 00h.
- R11: Identification mode ends on a single F0h write at any address from idle, or on AAh@5555h, 55h@2AAAh, F0h@5555h.
- R12: With topLock high, program or erase aimed at the top block (address bits [19:16] all ones) issues no request. wpLock does the same for all other blocks, and chip erase is refused if either lock is high. A refused program or erase still holds busy for its full duration.
- R13: rdData is registered. It updates one cycle after rdEn and holds its value while rdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Byte write strobe |
| rdEn | input | 1 | Byte read strobe |
| addr | input | ADDR_W | Byte address of the bus access |
| wrData | input | 8 | Write data |
| ppMode | input | 1 | Parallel-programming mode, enables chip erase |
| topLock | input | 1 | Lock for the top 64 KB block |
| wpLock | input | 1 | Lock for all blocks except the top one |
| arrRdData | input | 8 | Array read data for addr |
| rdData | output | 8 | Registered read result |
| busy | output | 1 | Internal operation in progress |
| opValid | output | 1 | One-cycle array operation request |
| opKind | output | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| opAddr | output | ADDR_W | Target address, aligned to the erase region |
| opData | output | 8 | Program data, FFh for erase |

## Verification
The hardest case to reach is command traffic that arrives while an internal operation is still counting. Reaching it needs a full launch first, then a complete new sequence packed inside the busy window, with nothing allowed to escape afterwards. The bench shortens both duration parameters so that an entire four-write program sequence fits inside one erase interval, then confirms that no request follows and that the sequencer is idle once busy drops. The toggle phase needs similar care. The bench places back-to-back reads straight after a launch, so that the first status read is known to show bit 6 at 0.

// File: rtl/jedec_seq_pkg.sv
package jedec_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } opKind_e;

  // Strobes from the command control to the datapath.
  typedef struct packed {
    logic    launch;
    opKind_e kind;
    logic    idMode;
  } seqStrobe_t;

endpackage

// File: rtl/jedec_seq_ctrl.sv
module jedec_seq_ctrl
  import jedec_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CMD_W  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              ppMode,
  input  logic              busy,
  output seqStrobe_t        strb
);

  typedef enum logic [2:0] {
    S_IDLE,
    S_UNL1,
    S_UNL2,
    S_PROG,
    S_ERA1,
    S_ERA2,
    S_ERA3
  } seqState_e;

  localparam logic [CMD_W-1:0] KEY_A = CMD_W'(16'h5555);
  localparam logic [CMD_W-1:0] KEY_B = CMD_W'(16'h2AAA);

  seqState_e state, stateNxt;
  logic      idMode, idModeNxt;
  logic      launch;
  opKind_e   kind;

  logic [CMD_W-1:0] cmdAddr;
  logic             atKeyA, atKeyB, isStart;
  seqState_e        brk;

  assign cmdAddr = addr[CMD_W-1:0];
  assign atKeyA  = (cmdAddr == KEY_A);
  assign atKeyB  = (cmdAddr == KEY_B);
  assign isStart = atKeyA && (wrData == 8'hAA);
  assign brk     = isStart ? S_UNL1 : S_IDLE;

  always_comb begin
    stateNxt  = state;
    idModeNxt = idMode;
    launch    = 1'b0;
    kind      = OP_PROG;
    if (wrEn && !busy) begin
      unique case (state)
        S_IDLE: begin
          if (isStart) stateNxt = S_UNL1;
          else if (wrData == 8'hF0) idModeNxt = 1'b0;
        end
        S_UNL1: stateNxt = (atKeyB && wrData == 8'h55) ? S_UNL2 : brk;
        S_UNL2: begin
          stateNxt = brk;
          if (atKeyA) begin
            unique case (wrData)
              8'hA0: stateNxt = S_PROG;
              8'h80: stateNxt = S_ERA1;
              8'h90: begin stateNxt = S_IDLE; idModeNxt = 1'b1; end
              8'hF0: begin stateNxt = S_IDLE; idModeNxt = 1'b0; end
              default: stateNxt = brk;
            endcase
          end
        end
        S_PROG: begin
          launch   = 1'b1;
          kind     = OP_PROG;
          stateNxt = S_IDLE;
        end
        S_ERA1: stateNxt = isStart ? S_ERA2 : S_IDLE;
        S_ERA2: stateNxt = (atKeyB && wrData == 8'h55) ? S_ERA3 : brk;
        S_ERA3: begin
          stateNxt = S_IDLE;
          if (wrData == 8'h30) begin
            launch = 1'b1;
            kind   = OP_SECT;
          end else if (wrData == 8'h50) begin
            launch = 1'b1;
            kind   = OP_BLK;
          end else if (wrData == 8'h10 && atKeyA && ppMode) begin
            launch = 1'b1;
            kind   = OP_CHIP;
          end else begin
            stateNxt = brk;
          end
        end
        default: stateNxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      idMode <= 1'b0;
    end else begin
      state  <= stateNxt;
      idMode <= idModeNxt;
    end
  end

  assign strb.launch = launch;
  assign strb.kind   = kind;
  assign strb.idMode = idMode;

endmodule

// File: rtl/jedec_seq_dp.sv
module jedec_seq_dp
  import jedec_seq_pkg::*;
#(
  parameter int          ADDR_W       = 20,
  parameter int          SECT_LSB     = 12,
  parameter int          BLK_LSB      = 16,
  parameter int          PROG_CYCLES  = 16,
  parameter int          ERASE_CYCLES = 64,
  parameter logic [7:0]  MFR_ID       = 8'hBF,
  parameter logic [7:0]  DEV_ID       = 8'h5B
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  input  logic [7:0]        arrRdData,
  input  logic              topLock,
  input  logic              wpLock,
  output logic              busy,
  output logic              opValid,
  output opKind_e           opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData,
  output logic [7:0]        rdData
);

  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0]  PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0]  ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [ADDR_W-1:0] SECT_MASK  = {ADDR_W{1'b1}} << SECT_LSB;
  localparam logic [ADDR_W-1:0] BLK_MASK   = {ADDR_W{1'b1}} << BLK_LSB;

  logic [CNT_W-1:0]  cnt;
  logic              polBit;
  logic              togBit;
  logic              inTop;
  logic              blocked;
  logic [ADDR_W-1:0] alignAddr;
  logic [7:0]        idByte;

  assign inTop = &addr[ADDR_W-1:BLK_LSB];

  always_comb begin
    unique case (strb.kind)
      OP_PROG: alignAddr = addr;
      OP_SECT: alignAddr = addr & SECT_MASK;
      OP_BLK:  alignAddr = addr & BLK_MASK;
      default: alignAddr = '0;
    endcase
    if (strb.kind == OP_CHIP) blocked = topLock | wpLock;
    else                      blocked = inTop ? topLock : wpLock;
  end

  always_comb begin
    if (addr == ADDR_W'(0))      idByte = MFR_ID;
    else if (addr == ADDR_W'(1)) idByte = DEV_ID;
    else                         idByte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cnt     <= '0;
      opValid <= 1'b0;
      opKind  <= OP_PROG;
      opAddr  <= '0;
      opData  <= 8'h00;
      polBit  <= 1'b0;
      togBit  <= 1'b0;
      rdData  <= 8'h00;
    end else begin
      opValid <= 1'b0;
      if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
      if (rdEn) begin
        if (busy) begin
          rdData <= {~polBit, togBit, 6'b0};
          togBit <= ~togBit;
        end else if (strb.idMode) begin
          rdData <= idByte;
        end else begin
          rdData <= arrRdData;
        end
      end
      if (strb.launch) begin
        busy    <= 1'b1;
        cnt     <= (strb.kind == OP_PROG) ? PROG_LOAD : ERASE_LOAD;
        opValid <= !blocked;
        opKind  <= strb.kind;
        opAddr  <= alignAddr;
        opData  <= (strb.kind == OP_PROG) ? wrData : 8'hFF;
        polBit  <= (strb.kind == OP_PROG) ? wrData[7] : 1'b1;
        togBit  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/jedec_cmd_seq.sv
module jedec_cmd_seq
  import jedec_seq_pkg::*;
#(
  parameter int          ADDR_W       = 20,
  parameter int          CMD_W        = 15,
  parameter int          SECT_LSB     = 12,
  parameter int          BLK_LSB      = 16,
  parameter int          PROG_CYCLES  = 16,
  parameter int          ERASE_CYCLES = 64,
  parameter logic [7:0]  MFR_ID       = 8'hBF,
  parameter logic [7:0]  DEV_ID       = 8'h5B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              ppMode,
  input  logic              topLock,
  input  logic              wpLock,
  input  logic [7:0]        arrRdData,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              opValid,
  output logic [1:0]        opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData
);

  seqStrobe_t strb;
  opKind_e    kindInt;

  jedec_seq_ctrl #(
    .ADDR_W(ADDR_W),
    .CMD_W (CMD_W)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .addr  (addr),
    .wrData(wrData),
    .ppMode(ppMode),
    .busy  (busy),
    .strb  (strb)
  );

  jedec_seq_dp #(
    .ADDR_W      (ADDR_W),
    .SECT_LSB    (SECT_LSB),
    .BLK_LSB     (BLK_LSB),
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES),
    .MFR_ID      (MFR_ID),
    .DEV_ID      (DEV_ID)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addr     (addr),
    .wrData   (wrData),
    .rdEn     (rdEn),
    .arrRdData(arrRdData),
    .topLock  (topLock),
    .wpLock   (wpLock),
    .busy     (busy),
    .opValid  (opValid),
    .opKind   (kindInt),
    .opAddr   (opAddr),
    .opData   (opData),
    .rdData   (rdData)
  );

  assign opKind = kindInt;

endmodule

// File: rtl/jedec_cmd_seq_chk.sv
module jedec_cmd_seq_chk #(
  parameter int ADDR_W       = 20,
  parameter int SECT_LSB     = 12,
  parameter int BLK_LSB      = 16,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic              ppMode,
  input logic              topLock,
  input logic [7:0]        rdData,
  input logic              busy,
  input logic              opValid,
  input logic [1:0]        opKind,
  input logic [ADDR_W-1:0] opAddr,
  input logic [7:0]        opData
);

  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int RUN_W   = $clog2(MAX_CYC + 2) + 1;

  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  p_op_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> busy);

  p_op_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> !opValid);

  p_erase_ff_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind != 2'd0) |-> (opData == 8'hFF));

  p_sect_align_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == 2'd1) |-> (opAddr[SECT_LSB-1:0] == '0));

  p_blk_align_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == 2'd2) |-> (opAddr[BLK_LSB-1:0] == '0));

  p_chip_pp_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == 2'd3) |-> $past(ppMode));

  p_top_lock_r12: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind != 2'd3 && (&opAddr[ADDR_W-1:BLK_LSB])) |-> !$past(topLock));

  p_busy_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < RUN_W'(MAX_CYC)));

  p_stat_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn && busy) |-> (rdData[5:0] == 6'b0));

endmodule

bind jedec_cmd_seq jedec_cmd_seq_chk #(
  .ADDR_W      (ADDR_W),
  .SECT_LSB    (SECT_LSB),
  .BLK_LSB     (BLK_LSB),
  .PROG_CYCLES (PROG_CYCLES),
  .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .rdEn   (rdEn),
  .ppMode (ppMode),
  .topLock(topLock),
  .rdData (rdData),
  .busy   (busy),
  .opValid(opValid),
  .opKind (opKind),
  .opAddr (opAddr),
  .opData (opData)
);

// File: tb/jedec_cmd_seq_test.sv
`timescale 1ns/100ps
module jedec_cmd_seq_test;

  localparam int AW = 20;
  localparam int PC = 6;
  localparam int EC = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wrData = 8'h00;
  logic          ppMode = 1'b0;
  logic          topLock = 1'b0;
  logic          wpLock = 1'b0;
  logic [7:0]    arrRdData;
  logic [7:0]    rdData;
  logic          busy;
  logic          opValid;
  logic [1:0]    opKind;
  logic [AW-1:0] opAddr;
  logic [7:0]    opData;

  int nChk = 0;
  int nFail = 0;
  int opCount = 0;
  logic [1:0]    lastKind;
  logic [AW-1:0] lastAddr;
  logic [7:0]    lastData;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] arrModel(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign arrRdData = arrModel(addr);

  jedec_cmd_seq #(.ADDR_W(AW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .ppMode(ppMode), .topLock(topLock), .wpLock(wpLock),
    .arrRdData(arrRdData), .rdData(rdData), .busy(busy), .opValid(opValid),
    .opKind(opKind), .opAddr(opAddr), .opData(opData)
  );

  always @(posedge clk) begin
    if (opValid) begin
      opCount  <= opCount + 1;
      lastKind <= opKind;
      lastAddr <= opAddr;
      lastData <= opData;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic progSeq(input logic [AW-1:0] a, input logic [7:0] d);
    wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'hA0); wr(a, d);
  endtask

  task automatic eraseSeq(input logic [AW-1:0] a, input logic [7:0] d);
    wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'h80);
    wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55); wr(a, d);
  endtask

  task automatic busyLen(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    int base;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0 && opValid == 1'b0, "R1 busy/opValid", {busy, opValid}, 0);
    chk(rdData == 8'h00, "R1 rdData", rdData, 0);
    rstN = 1'b1;
    rd(20'h00000, v);
    chk(v == arrModel(20'h00000), "R1 not id mode", v, arrModel(20'h00000));

    // R2 / R9 sweep over program targets and data
    for (int i = 0; i < 16; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      a = AW'(i * 32'h0_1111 + 32'h123) & 20'hEFFFF;
      d = 8'(i * 17) ^ 8'h5A;
      base = opCount;
      progSeq(a, d);
      rd(20'h00042, v);
      chk(v == {~d[7], 7'b0}, "R9 first status read", v, {~d[7], 7'b0});
      waitIdle();
      chk(opCount == base + 1, "R2 one request", opCount, base + 1);
      chk(lastKind == 2'd0 && lastAddr == a && lastData == d, "R2 fields",
          {lastKind, lastAddr, lastData}, {2'd0, a, d});
    end

    // R8 program busy length
    progSeq(20'h01234, 8'h11);
    busyLen(n);
    chk(n == PC, "R8 program busy length", n, PC);
    waitIdle();

    // R9 toggle and erase polarity, then true data
    eraseSeq(20'h23456, 8'h30);
    rd(20'h23456, v);
    chk(v == 8'h00, "R9 erase read 1", v, 8'h00);
    rd(20'h23456, v);
    chk(v == 8'h40, "R9 erase read 2 toggles", v, 8'h40);
    rd(20'h23456, v);
    chk(v == 8'h00, "R9 erase read 3 toggles", v, 8'h00);
    waitIdle();
    rd(20'h23456, v);
    chk(v == arrModel(20'h23456), "R9 true data after busy", v, arrModel(20'h23456));
    // R3 sector erase fields
    chk(lastKind == 2'd1 && lastAddr == 20'h23000 && lastData == 8'hFF, "R3 sector erase",
        {lastKind, lastAddr, lastData}, {2'd1, 20'h23000, 8'hFF});
    // R13 rdData holds
    repeat (3) @(negedge clk);
    chk(rdData == arrModel(20'h23456), "R13 rdData holds", rdData, arrModel(20'h23456));

    // R4 block erase + R8 erase length
    eraseSeq(20'h4ABCD, 8'h50);
    busyLen(n);
    chk(n == EC, "R8 erase busy length", n, EC);
    waitIdle();
    chk(lastKind == 2'd2 && lastAddr == 20'h40000 && lastData == 8'hFF, "R4 block erase",
        {lastKind, lastAddr, lastData}, {2'd2, 20'h40000, 8'hFF});

    // R8 writes while busy are ignored
    base = opCount;
    eraseSeq(20'h31111, 8'h30);
    progSeq(20'h05000, 8'h77);
    waitIdle();
    chk(opCount == base + 1, "R8 writes during busy ignored", opCount, base + 1);
    chk(busy == 1'b0, "R8 idle after ignored writes", busy, 0);
    wr(20'h05000, 8'h77);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && opCount == base + 1, "R8 sequencer idle", opCount, base + 1);

    // R5 chip erase gated by ppMode
    base = opCount;
    ppMode = 1'b0;
    eraseSeq(20'h05555, 8'h10);
    @(negedge clk);
    chk(busy == 1'b0, "R5 chip erase refused busy", busy, 0);
    waitIdle();
    chk(opCount == base, "R5 chip erase refused", opCount, base);
    ppMode = 1'b1;
    eraseSeq(20'h05555, 8'h10);
    waitIdle();
    chk(opCount == base + 1 && lastKind == 2'd3 && lastAddr == '0, "R5 chip erase",
        {lastKind, lastAddr}, {2'd3, 20'h0});
    ppMode = 1'b0;

    // R6 only low 15 address bits compared
    base = opCount;
    wr(20'hA5555, 8'hAA); wr(20'h7AAAA, 8'h55); wr(20'hFD555, 8'hA0); wr(20'h06006, 8'h66);
    waitIdle();
    chk(opCount == base + 1 && lastAddr == 20'h06006, "R6 high bits ignored", opCount, base + 1);
    wr(20'h01555, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'hA0); wr(20'h06007, 8'h67);
    waitIdle();
    chk(opCount == base + 1, "R6 low-bit mismatch breaks", opCount, base + 1);

    // R7 broken sequence, restart on AA@5555
    wr(20'h05555, 8'hAA); wr(20'h01234, 8'h55); wr(20'h05555, 8'hA0); wr(20'h00100, 8'h12);
    waitIdle();
    chk(opCount == base + 1, "R7 break to idle", opCount, base + 1);
    wr(20'h05555, 8'hAA); wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'hA0);
    wr(20'h00200, 8'h21);
    waitIdle();
    chk(opCount == base + 2 && lastAddr == 20'h00200, "R7 restart on AA", opCount, base + 2);

    // R10 / R11 identification mode
    wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'h90);
    rd(20'h00000, v); chk(v == 8'hBF, "R10 maker id", v, 8'hBF);
    rd(20'h00001, v); chk(v == 8'h5B, "R10 device id", v, 8'h5B);
    rd(20'h00002, v); chk(v == 8'h00, "R10 other addr", v, 8'h00);
    wr(20'h12345, 8'hF0);
    rd(20'h00001, v); chk(v == arrModel(20'h00001), "R11 single F0 exit", v, arrModel(20'h00001));
    wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'h90);
    rd(20'h00000, v); chk(v == 8'hBF, "R10 re-entry", v, 8'hBF);
    wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'hF0);
    rd(20'h00000, v); chk(v == arrModel(20'h00000), "R11 three-write exit", v, arrModel(20'h00000));

    // R12 protection
    base = opCount;
    topLock = 1'b1;
    progSeq(20'hF0123, 8'h44);
    busyLen(n);
    chk(n == PC, "R12 refused program still busy", n, PC);
    waitIdle();
    chk(opCount == base, "R12 top lock blocks program", opCount, base);
    progSeq(20'h10000, 8'h45);
    waitIdle();
    chk(opCount == base + 1 && lastAddr == 20'h10000, "R12 top lock spares lower", opCount, base + 1);
    eraseSeq(20'hF8888, 8'h50);
    waitIdle();
    chk(opCount == base + 1, "R12 top lock blocks erase", opCount, base + 1);
    topLock = 1'b0; wpLock = 1'b1;
    progSeq(20'h10001, 8'h46);
    waitIdle();
    chk(opCount == base + 1, "R12 wp lock blocks lower", opCount, base + 1);
    progSeq(20'hF0010, 8'h47);
    waitIdle();
    chk(opCount == base + 2 && lastAddr == 20'hF0010, "R12 wp lock spares top", opCount, base + 2);
    ppMode = 1'b1;
    eraseSeq(20'h05555, 8'h10);
    waitIdle();
    chk(opCount == base + 2, "R12 chip erase locked", opCount, base + 2);
    wpLock = 1'b0;
    eraseSeq(20'hF8888, 8'h50);
    waitIdle();
    chk(opCount == base + 3 && lastAddr == 20'hF0000, "R12 top erase unlocked", opCount, base + 3);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule